// File: doc/BRIEF.md
# Core Control Register Unit

This block holds, for a single processor core inside a mode-entry controller, the per-mode run settings and the boot address. The mode controller reports the mode in force, the mode being entered and whether a switch is under way; from these and the stored settings the block drives the core's clock enable and tells whether a gated core counts as frozen or disabled.

Software reaches three registers over a simple register bus with an access size and a privilege level: a run-setting register, a boot-address register and a status register holding a configuration-error flag that is cleared by writing one. Writes to the boot-address register that arrive while a switch is running are dropped and set the error flag. If software has armed the reset-on-switch bit, the completion of a switch into a mode where the core is set to run triggers a one-cycle core reset request, and the stored boot address is handed to the core.

Top module: `core_ctl_unit`

## Requirements
- R1: Mode codes on `cur_mode`/`tgt_mode` are RESET=0, TEST=1, SAFE=2, DRUN=3, RUN0=4, RUN1=5 (6 and 7 reserved). The run-setting register (byte offset 0x0) gives each mode one bit: TEST bit 1, SAFE bit 2, DRUN bit 3, RUN0 bit 4, RUN1 bit 5. Outside a switch, `core_clk_en` equals the bit of `cur_mode` one clock after `cur_mode` or the register changes.
- R2: Exactly one of `core_clk_en`, `core_frozen`, `core_disabled` is high at all times; a gated core is reported frozen in TEST, SAFE, DRUN and RUN0 and disabled in RUN1, RESET and the reserved codes.
- R3: In RESET mode and the reserved codes the core is gated whatever the register holds; run-setting bits 0 and 15:6 are not writable and read 0.
- R4: While `trans_busy` is high the three core state outputs keep the values they had when it rose; on the first cycle with `trans_busy` low they follow `cur_mode` again per R1.
- R5: The boot-address register (byte offset 0x4) holds the boot address in bits 31:2, the reset-on-switch arm bit in bit 0, and reads bit 1 as 0. After reset it holds `cfg_boot_addr[31:2]` with the arm bit clear. Only word writes (size code 2) change it; byte (0) and halfword (1) writes are ignored and do not set the error flag.
- R6: A privileged write to the boot-address register of any size while `trans_busy` is high is discarded and sets the error flag, seen on `cfg_err_irq` and as bit 0 of the status register (byte offset 0x8). Writing 1 to that bit clears it, writing 0 leaves it; a set in the same cycle wins.
- R7: Privilege codes are user=0, supervisor=1, test=2. A user write changes no register and drives `bus_err` high in the same cycle; user reads return register contents. Supervisor and test writes take effect with `bus_err` low.
- R8: On the first cycle after a switch completes (`trans_busy` falls), if the arm bit is set and the run-setting bit of `tgt_mode` is 1, `core_rst_req` is high for exactly one cycle and `core_boot_addr` takes the stored address. The arm bit stays set afterwards.
- R9: A completed switch into a mode whose bit is 0, or into RESET, gives no reset request and leaves `core_boot_addr` unchanged; after reset `core_boot_addr` equals `cfg_boot_addr` with bits 1:0 cleared.
- R10: The run-setting register accepts privileged halfword and word writes (bits 15:0 of the write data) at any time; its reset value sets TEST, SAFE, DRUN and RUN0 (0x001E).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_boot_addr | input | 32 | Boot address loaded at reset (bits 1:0 ignored) |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_priv | input | 2 | Privilege: 0 user, 1 supervisor, 2 test |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_err | output | 1 | Access refused (user write) |
| cur_mode | input | 3 | Mode currently in force |
| tgt_mode | input | 3 | Mode being entered |
| trans_busy | input | 1 | Mode switch in progress |
| core_clk_en | output | 1 | Core clock enable |
| core_frozen | output | 1 | Core gated, frozen state |
| core_disabled | output | 1 | Core gated, disabled state |
| core_boot_addr | output | 32 | Boot address presented to the core |
| core_rst_req | output | 1 | One-cycle core reset request |
| cfg_err_irq | output | 1 | Configuration-error flag |

## Verification
The embedded properties watch, on every cycle, that exactly one core state is reported, that RESET mode gates the core, that the outputs freeze during a switch, that the reset request never lasts two cycles and never follows a switch into RESET, and that refused, narrow and in-switch writes leave the boot-address register alone with the right effect on the error flag. Only the bench's scenarios show the actual mapping from each mode code to its register bit, the readback layouts and reset values, the write-one-to-clear behaviour, and that a qualifying switch delivers the exact stored address while a non-qualifying one keeps the old address.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

   localparam logic [2:0] MODE_RESET = 3'd0;
   localparam logic [2:0] MODE_TEST  = 3'd1;
   localparam logic [2:0] MODE_SAFE  = 3'd2;
   localparam logic [2:0] MODE_DRUN  = 3'd3;
   localparam logic [2:0] MODE_RUN0  = 3'd4;
   localparam logic [2:0] MODE_RUN1  = 3'd5;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam logic [1:0] PRIV_USER = 2'd0;
   localparam logic [1:0] PRIV_SUP  = 2'd1;
   localparam logic [1:0] PRIV_TEST = 2'd2;

   // Run-setting bit for a mode; 0 means the mode has no bit (core always gated).
   function automatic logic [3:0] mode_bit(input logic [2:0] m);
      case (m)
         MODE_TEST: return 4'd1;
         MODE_SAFE: return 4'd2;
         MODE_DRUN: return 4'd3;
         MODE_RUN0: return 4'd4;
         MODE_RUN1: return 4'd5;
         default:   return 4'd0;
      endcase
   endfunction

   function automatic logic mode_runs(input logic [2:0] m, input logic [15:0] ctl);
      logic [3:0] b;
      b = mode_bit(m);
      if (b == 4'd0) return 1'b0;
      return ctl[b];
   endfunction

   // Gated core counts as frozen in these modes, disabled elsewhere.
   function automatic logic mode_freezes(input logic [2:0] m);
      return (m == MODE_TEST) || (m == MODE_SAFE) || (m == MODE_DRUN) || (m == MODE_RUN0);
   endfunction

endpackage

// File: rtl/ccu_bus_regs.sv
module ccu_bus_regs
   import ccu_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFF_W     = 4,
   parameter int unsigned CTL_W     = 16,
   parameter int unsigned MODE_BITS = 5,
   parameter logic [3:0]  OFF_CTL   = 4'h0,
   parameter logic [3:0]  OFF_ADDR  = 4'h4,
   parameter logic [3:0]  OFF_STAT  = 4'h8,
   parameter logic [15:0] CTL_RESET = 16'h001E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] cfg_boot_addr,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [OFF_W-1:0]  bus_off,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [1:0]        bus_size,
   input  logic [1:0]        bus_priv,
   input  logic              trans_busy,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic [CTL_W-1:0]  ctl_q,
   output logic [DATA_W-3:0] addr_q,
   output logic              arm_q,
   output logic              err_q
);
   localparam logic [CTL_W-1:0] CTL_WMASK = CTL_W'((1 << (MODE_BITS + 1)) - 2);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("ccu_bus_regs: DATA_W must be 32");
      end
      if (CTL_W <= MODE_BITS) begin : g_bad_ctl
         $error("ccu_bus_regs: CTL_W too small for the mode bits");
      end
      if (OFF_CTL == OFF_ADDR || OFF_CTL == OFF_STAT || OFF_ADDR == OFF_STAT) begin : g_bad_map
         $error("ccu_bus_regs: register offsets collide");
      end
   endgenerate

   logic wr_any, priv_ok;
   logic hit_ctl, hit_addr, hit_stat;
   logic wr_ctl, wr_addr_try, wr_addr, err_set, err_clr;
   logic wdata_unused;

   assign wdata_unused = bus_wdata[1];
   assign wr_any   = bus_sel & bus_wr;
   assign priv_ok  = (bus_priv == PRIV_SUP) | (bus_priv == PRIV_TEST);
   assign hit_ctl  = (bus_off == OFF_W'(OFF_CTL));
   assign hit_addr = (bus_off == OFF_W'(OFF_ADDR));
   assign hit_stat = (bus_off == OFF_W'(OFF_STAT));

   assign wr_ctl      = wr_any & priv_ok & hit_ctl & ((bus_size == SZ_HALF) | (bus_size == SZ_WORD));
   assign wr_addr_try = wr_any & priv_ok & hit_addr;
   assign wr_addr     = wr_addr_try & ~trans_busy & (bus_size == SZ_WORD);
   assign err_set     = wr_addr_try & trans_busy;
   assign err_clr     = wr_any & priv_ok & hit_stat & bus_wdata[0];
   assign bus_err     = wr_any & ~priv_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= CTL_RESET[CTL_W-1:0] & CTL_WMASK;
         addr_q <= cfg_boot_addr[DATA_W-1:2];
         arm_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0] & CTL_WMASK;
         if (wr_addr) begin
            addr_q <= bus_wdata[DATA_W-1:2];
            arm_q  <= bus_wdata[0];
         end
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (hit_ctl)       bus_rdata = DATA_W'(ctl_q);
         else if (hit_addr) bus_rdata = {addr_q, 1'b0, arm_q};
         else if (hit_stat) bus_rdata = DATA_W'(err_q);
      end
   end

   a_r7_user_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && !priv_ok) |=> ($stable(ctl_q) && $stable(addr_q) && $stable(arm_q)));

   a_r6_busy_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && priv_ok && hit_addr && trans_busy) |=> (err_q && $stable(addr_q) && $stable(arm_q)));

   a_r5_narrow_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && hit_addr && !trans_busy && bus_size != SZ_WORD)
      |=> ($stable(addr_q) && $stable(arm_q) && !$rose(err_q)));

endmodule

// File: rtl/ccu_mode_gate.sv
module ccu_mode_gate
   import ccu_pkg::*;
#(
   parameter int unsigned CTL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cur_mode,
   input  logic             trans_busy,
   input  logic [CTL_W-1:0] ctl_q,
   output logic             core_clk_en,
   output logic             core_frozen,
   output logic             core_disabled
);
   generate
      if (CTL_W != 16) begin : g_bad_ctl
         $error("ccu_mode_gate: mode lookup expects a 16-bit run-setting register");
      end
   endgenerate

   logic run_q, frz_kind_q;

   // Outside a switch the setting of the mode in force is sampled each cycle;
   // during a switch the previous setting is kept.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         frz_kind_q <= 1'b0;
      end else if (!trans_busy) begin
         run_q      <= mode_runs(cur_mode, 16'(ctl_q));
         frz_kind_q <= mode_freezes(cur_mode);
      end
   end

   assign core_clk_en   = run_q;
   assign core_frozen   = ~run_q & frz_kind_q;
   assign core_disabled = ~run_q & ~frz_kind_q;

   a_r2_single_state: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({core_clk_en, core_frozen, core_disabled}) == 1);

   a_r3_reset_mode_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!trans_busy && cur_mode == MODE_RESET) |=> (!core_clk_en && core_disabled));

   a_r4_hold_in_switch: assert property (@(posedge clk) disable iff (!rst_n)
      trans_busy |=> $stable({core_clk_en, core_frozen, core_disabled}));

endmodule

// File: rtl/ccu_switch_reset.sv
module ccu_switch_reset
   import ccu_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned CTL_W          = 16,
   parameter bit          BOOT_ADDR_LIVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trans_busy,
   input  logic [2:0]        tgt_mode,
   input  logic [CTL_W-1:0]  ctl_q,
   input  logic              arm_q,
   input  logic [DATA_W-3:0] addr_q,
   input  logic [DATA_W-3:0] cfg_addr,
   output logic              core_rst_req,
   output logic [DATA_W-1:0] core_boot_addr
);
   logic trans_q, done, fire, rst_q;

   assign done = trans_q & ~trans_busy;
   assign fire = done & arm_q & mode_runs(tgt_mode, 16'(ctl_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trans_q <= 1'b0;
         rst_q   <= 1'b0;
      end else begin
         trans_q <= trans_busy;
         rst_q   <= fire;
      end
   end

   assign core_rst_req = rst_q;

   generate
      if (BOOT_ADDR_LIVE) begin : g_live
         logic [DATA_W-3:0] cfg_unused;
         assign cfg_unused     = cfg_addr;
         assign core_boot_addr = {addr_q, 2'b00};
      end else begin : g_latched
         logic [DATA_W-3:0] boot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    boot_q <= cfg_addr;
            else if (fire) boot_q <= addr_q;
         end
         assign core_boot_addr = {boot_q, 2'b00};

         a_r8_boot_loaded: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (core_boot_addr == {$past(addr_q), 2'b00}));

         a_r9_boot_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !fire |=> $stable(core_boot_addr));
      end
   endgenerate

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_req |=> !core_rst_req);

   a_r9_no_reset_target: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tgt_mode == MODE_RESET) |=> !core_rst_req);

endmodule

// File: rtl/core_ctl_unit.sv
module core_ctl_unit
   import ccu_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned OFF_W          = 4,
   parameter int unsigned CTL_W          = 16,
   parameter int unsigned MODE_BITS      = 5,
   parameter logic [15:0] CTL_RESET      = 16'h001E,
   parameter bit          BOOT_ADDR_LIVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] cfg_boot_addr,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [OFF_W-1:0]  bus_off,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [1:0]        bus_size,
   input  logic [1:0]        bus_priv,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic [2:0]        cur_mode,
   input  logic [2:0]        tgt_mode,
   input  logic              trans_busy,
   output logic              core_clk_en,
   output logic              core_frozen,
   output logic              core_disabled,
   output logic [DATA_W-1:0] core_boot_addr,
   output logic              core_rst_req,
   output logic              cfg_err_irq
);
   logic [CTL_W-1:0]  ctl_q;
   logic [DATA_W-3:0] addr_q;
   logic              arm_q;
   logic [1:0]        cfg_low_unused;

   assign cfg_low_unused = cfg_boot_addr[1:0];

   ccu_bus_regs #(
      .DATA_W(DATA_W), .OFF_W(OFF_W), .CTL_W(CTL_W), .MODE_BITS(MODE_BITS),
      .OFF_CTL(4'h0), .OFF_ADDR(4'h4), .OFF_STAT(4'h8), .CTL_RESET(CTL_RESET)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .cfg_boot_addr(cfg_boot_addr),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_off(bus_off), .bus_wdata(bus_wdata),
      .bus_size(bus_size), .bus_priv(bus_priv), .trans_busy(trans_busy),
      .bus_rdata(bus_rdata), .bus_err(bus_err),
      .ctl_q(ctl_q), .addr_q(addr_q), .arm_q(arm_q), .err_q(cfg_err_irq)
   );

   ccu_mode_gate #(.CTL_W(CTL_W)) gate_i (
      .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .trans_busy(trans_busy),
      .ctl_q(ctl_q), .core_clk_en(core_clk_en), .core_frozen(core_frozen),
      .core_disabled(core_disabled)
   );

   ccu_switch_reset #(
      .DATA_W(DATA_W), .CTL_W(CTL_W), .BOOT_ADDR_LIVE(BOOT_ADDR_LIVE)
   ) swrst_i (
      .clk(clk), .rst_n(rst_n), .trans_busy(trans_busy), .tgt_mode(tgt_mode),
      .ctl_q(ctl_q), .arm_q(arm_q), .addr_q(addr_q),
      .cfg_addr(cfg_boot_addr[DATA_W-1:2]),
      .core_rst_req(core_rst_req), .core_boot_addr(core_boot_addr)
   );

endmodule

// File: tb/core_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module core_ctl_unit_tb_top;
   localparam int CLK_HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_boot_addr = 32'h0040_0003;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_off = 4'h0;
   logic [31:0] bus_wdata = '0;
   logic [1:0]  bus_size = 2'd2, bus_priv = 2'd1;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [2:0]  cur_mode = 3'd0, tgt_mode = 3'd0;
   logic        trans_busy = 1'b0;
   logic        core_clk_en, core_frozen, core_disabled, core_rst_req, cfg_err_irq;
   logic [31:0] core_boot_addr;

   int checks = 0;
   int failures = 0;
   logic [15:0] ctl_m = 16'h001E;   // bench model of the run-setting register
   logic        last_err;
   logic [31:0] rd;

   always #(CLK_HALF) clk = ~clk;

   core_ctl_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_boot_addr(cfg_boot_addr),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_off(bus_off), .bus_wdata(bus_wdata),
      .bus_size(bus_size), .bus_priv(bus_priv), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .cur_mode(cur_mode), .tgt_mode(tgt_mode), .trans_busy(trans_busy),
      .core_clk_en(core_clk_en), .core_frozen(core_frozen), .core_disabled(core_disabled),
      .core_boot_addr(core_boot_addr), .core_rst_req(core_rst_req), .cfg_err_irq(cfg_err_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R1 mapping: TEST 1, SAFE 2, DRUN 3, RUN0 4, RUN1 5; other codes never run.
   function automatic logic exp_run(input logic [2:0] m, input logic [15:0] c);
      if (m >= 3'd1 && m <= 3'd5) return c[m];
      return 1'b0;
   endfunction
   function automatic logic exp_frz(input logic [2:0] m);
      return (m >= 3'd1 && m <= 3'd4);
   endfunction

   task automatic wr(input logic [3:0] off, input logic [31:0] d,
                     input logic [1:0] sz, input logic [1:0] pv);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_off = off; bus_wdata = d;
      bus_size = sz; bus_priv = pv;
      #1 last_err = bus_err;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rdreg(input logic [3:0] off, input logic [1:0] pv);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_off = off; bus_priv = pv;
      #1 rd = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic check_state(input string req, input logic [2:0] m);
      logic r;
      r = exp_run(m, ctl_m);
      chk({req, " clk_en"}, 32'(core_clk_en), 32'(r));
      chk({req, " frozen"}, 32'(core_frozen), 32'(!r && exp_frz(m)));
      chk({req, " disabled"}, 32'(core_disabled), 32'(!r && !exp_frz(m)));
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk);
      cur_mode = m;
      @(negedge clk);
   endtask

   // Runs a switch to t; returns reset request seen on the two cycles after completion.
   task automatic do_switch(input logic [2:0] t, output logic p0, output logic p1);
      @(negedge clk);
      trans_busy = 1'b1; tgt_mode = t;
      repeat (3) @(negedge clk);
      cur_mode = t; trans_busy = 1'b0;
      @(posedge clk); #1 p0 = core_rst_req;
      @(posedge clk); #1 p1 = core_rst_req;
   endtask

   task automatic t_reset_state;
      chk("R9 reset clk_en", 32'(core_clk_en), 32'd0);
      chk("R3 reset disabled", 32'(core_disabled), 32'd1);
      chk("R8 reset no rst_req", 32'(core_rst_req), 32'd0);
      chk("R9 reset boot addr", core_boot_addr, 32'h0040_0000);
      rdreg(4'h0, 2'd0); chk("R10 ctl reset value", rd, 32'h0000_001E);
      rdreg(4'h4, 2'd0); chk("R5 addr reset value", rd, 32'h0040_0000);
      rdreg(4'h8, 2'd0); chk("R6 flag reset", rd, 32'd0);
   endtask

   task automatic t_gating;
      logic [2:0] modes [5] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
      foreach (modes[i]) begin
         set_mode(modes[i]);
         check_state("R1 R2 gating 1E", modes[i]);
      end
      wr(4'h0, 32'h0000_0022, 2'd1, 2'd1); ctl_m = 16'h0022;
      foreach (modes[i]) begin
         set_mode(modes[i]);
         check_state("R10 R2 gating 22", modes[i]);
      end
   endtask

   task automatic t_reset_mode;
      wr(4'h0, 32'hFFFF_FFFF, 2'd2, 2'd1); ctl_m = 16'h003E;
      rdreg(4'h0, 2'd1); chk("R3 ctl mask", rd, 32'h0000_003E);
      set_mode(3'd0); check_state("R3 RESET gated", 3'd0);
      set_mode(3'd6); check_state("R3 reserved gated", 3'd6);
      wr(4'h0, 32'h0000_0002, 2'd0, 2'd1);
      rdreg(4'h0, 2'd1); chk("R10 byte ctl ignored", rd, 32'h0000_003E);
   endtask

   task automatic t_switch_hold;
      logic p0, p1;
      wr(4'h0, 32'h0000_0020, 2'd2, 2'd1); ctl_m = 16'h0020;
      set_mode(3'd5); check_state("R1 RUN1 on", 3'd5);
      @(negedge clk); trans_busy = 1'b1; tgt_mode = 3'd2;
      @(negedge clk); cur_mode = 3'd2;
      repeat (3) begin
         @(negedge clk);
         chk("R4 hold clk_en", 32'(core_clk_en), 32'd1);
         chk("R4 hold frozen", 32'(core_frozen), 32'd0);
      end
      trans_busy = 1'b0;
      @(posedge clk); #1;
      check_state("R4 after switch", 3'd2);
      p0 = core_rst_req; p1 = 1'b0;
      chk("R9 unarmed no pulse", 32'({p0, p1}), 32'd0);
   endtask

   task automatic t_busy_write;
      @(negedge clk); trans_busy = 1'b1; tgt_mode = 3'd3;
      wr(4'h4, 32'h1234_5679, 2'd2, 2'd1);
      chk("R6 flag set", 32'(cfg_err_irq), 32'd1);
      rdreg(4'h4, 2'd1); chk("R6 addr kept", rd, 32'h0040_0000);
      wr(4'h4, 32'h1234_5678, 2'd0, 2'd2);
      @(negedge clk); cur_mode = 3'd3; trans_busy = 1'b0;
      @(negedge clk);
      rdreg(4'h8, 2'd0); chk("R6 status bit", rd, 32'd1);
      wr(4'h8, 32'h0000_0000, 2'd2, 2'd1);
      chk("R6 write 0 keeps", 32'(cfg_err_irq), 32'd1);
      wr(4'h8, 32'h0000_0001, 2'd2, 2'd1);
      chk("R6 w1c clears", 32'(cfg_err_irq), 32'd0);
   endtask

   task automatic t_narrow;
      wr(4'h4, 32'hAAAA_AAA8, 2'd0, 2'd1);
      wr(4'h4, 32'hBBBB_BBB8, 2'd1, 2'd1);
      rdreg(4'h4, 2'd1); chk("R5 narrow ignored", rd, 32'h0040_0000);
      chk("R5 narrow no flag", 32'(cfg_err_irq), 32'd0);
      wr(4'h4, 32'h0000_2003, 2'd2, 2'd2);
      rdreg(4'h4, 2'd1); chk("R5 word layout", rd, 32'h0000_2001);
      wr(4'h4, 32'h0000_2000, 2'd2, 2'd1);
   endtask

   task automatic t_user;
      wr(4'h0, 32'h0000_0000, 2'd2, 2'd0);
      chk("R7 user bus_err", 32'(last_err), 32'd1);
      wr(4'h4, 32'hFFFF_FFFD, 2'd2, 2'd0);
      rdreg(4'h0, 2'd0); chk("R7 user ctl unchanged", rd, 32'(ctl_m));
      rdreg(4'h4, 2'd0); chk("R7 user addr unchanged", rd, 32'h0000_2000);
      chk("R7 user no flag", 32'(cfg_err_irq), 32'd0);
      wr(4'h0, 32'h0000_001E, 2'd2, 2'd2); ctl_m = 16'h001E;
      chk("R7 test priv no bus_err", 32'(last_err), 32'd0);
      rdreg(4'h0, 2'd0); chk("R7 test priv wrote", rd, 32'h0000_001E);
   endtask

   task automatic t_switch_reset;
      logic p0, p1;
      wr(4'h4, 32'h0000_1001, 2'd2, 2'd1);
      do_switch(3'd3, p0, p1);
      chk("R8 pulse first cycle", 32'(p0), 32'd1);
      chk("R8 pulse one cycle", 32'(p1), 32'd0);
      chk("R8 boot loaded", core_boot_addr, 32'h0000_1000);
      rdreg(4'h4, 2'd1); chk("R8 arm stays", rd, 32'h0000_1001);
      wr(4'h4, 32'h0000_3001, 2'd2, 2'd1);
      do_switch(3'd5, p0, p1);
      chk("R9 off target no pulse", 32'({p0, p1}), 32'd0);
      chk("R9 boot kept off", core_boot_addr, 32'h0000_1000);
      do_switch(3'd0, p0, p1);
      chk("R9 RESET target no pulse", 32'({p0, p1}), 32'd0);
      chk("R9 boot kept RESET", core_boot_addr, 32'h0000_1000);
      do_switch(3'd1, p0, p1);
      chk("R8 second pulse", 32'({p0, p1}), 32'd2);
      chk("R8 new boot", core_boot_addr, 32'h0000_3000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_gating();
      t_reset_mode();
      t_switch_hold();
      t_busy_write();
      t_narrow();
      t_user();
      t_switch_reset();
      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(2 * CLK_HALF * 150000);
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule